// File: doc/BRIEF.md
# Programmable Baud Tick Generator

This block produces the timing pulses for an asynchronous serial port. A 13-bit modulo divisor is held in two byte-wide registers on a simple write bus. The block emits a 16x oversampling tick once every divisor-count bus clocks, and a bit-rate tick on every sixteenth oversampling tick. The serial bit rate is therefore the bus clock divided by sixteen times the divisor.

The divisor is loaded in two steps. A write to the upper register only stages its five bits. A write to the lower register commits the staged upper half and the new lower byte together, so the counter never runs on a half-updated divisor. A divisor of zero stops the generator. The generator also stays stopped while both the receive enable and the transmit enable are low. After reset the divisor is 4, and the generator waits for the first enable.

Top module: `baud_tick_gen`

## Requirements
- R1: On reset the upper register reads 0x00 and the lower register reads 0x04, so the divisor is 4. No tick is produced while both enables are low.
- R2: A write with `sel_lo`=0 changes neither the upper register readback nor the tick rate. The value only waits in a staging buffer.
- R3: A write with `sel_lo`=1 commits the staged upper half (divisor bits 12:8, register bits 4:0) together with the lower byte (divisor bits 7:0). Reads with `sel_lo`=1 return the lower byte, and reads with `sel_lo`=0 return the committed upper half.
- R4: For a divisor BR from 1 to 8191, `ovs_tick` is a one-cycle pulse that repeats every BR clocks.
- R5: `bit_tick` pulses together with every 16th `ovs_tick`, and at no other time.
- R6: With a divisor of zero, neither tick is ever produced.
- R7: The generator runs when either `rx_en` or `tx_en` is high, and it is stopped and cleared when both are low.
- R8: A commit of a new divisor, or a change from stopped to running, restarts the count. The first `ovs_tick` then comes in the BR-th cycle after the restart, and the first `bit_tick` in the 16·BR-th.
- R9: Upper register bits 7:5 are not implemented. They always read 0 and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_lo | input | 1 | Register select: 0 selects the upper byte, 1 selects the lower byte |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Readback of the selected register (combinational) |
| rx_en | input | 1 | Receiver enable |
| tx_en | input | 1 | Transmitter enable |
| ovs_tick | output | 1 | 16x oversampling tick, one cycle wide |
| bit_tick | output | 1 | Bit-rate tick, coincident with every 16th oversampling tick |

## Verification
Any corruption of the committed divisor appears at once at `rd_data`. It also shows at the ticks within one divisor period, because the first pulse after a restart arrives early or late. A staging buffer that leaks into the working value is visible right after the upper write, before any lower write. A bit counter that is off by one misplaces the first `bit_tick` within 16 divisor periods. An oversample counter that fails to clear on an enable edge or on a commit gives a runt first period, and this appears in the very first tick position.

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int DIV_W   = 13,
  parameter int OVS     = 16,
  parameter int RST_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_lo,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       rx_en,
  input  logic       tx_en,
  output logic       ovs_tick,
  output logic       bit_tick
);
  localparam int HI_W = DIV_W - 8;
  localparam int BC_W = $clog2(OVS);

  logic [HI_W-1:0]  hi_pend, hi_work;
  logic [7:0]       lo_work;
  logic [DIV_W-1:0] div, ovs_cnt;
  logic [BC_W-1:0]  bit_cnt;
  logic             commit, run;

  assign commit = wr_en & sel_lo;
  assign div    = {hi_work, lo_work};
  assign run    = (rx_en | tx_en) && (div != '0);

  assign ovs_tick = run && (ovs_cnt == div - DIV_W'(1));
  assign bit_tick = ovs_tick && (bit_cnt == BC_W'(OVS - 1));

  assign rd_data = sel_lo ? lo_work : {{(8-HI_W){1'b0}}, hi_work};

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_pend <= '0;
      hi_work <= HI_W'(RST_DIV >> 8);
      lo_work <= 8'(RST_DIV);
    end else if (wr_en) begin
      if (sel_lo) begin
        hi_work <= hi_pend;
        lo_work <= wr_data;
      end else begin
        hi_pend <= wr_data[HI_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || commit || !run) begin
      ovs_cnt <= '0;
      bit_cnt <= '0;
    end else if (ovs_tick) begin
      ovs_cnt <= '0;
      bit_cnt <= bit_tick ? '0 : bit_cnt + BC_W'(1);
    end else begin
      ovs_cnt <= ovs_cnt + DIV_W'(1);
    end
  end

  assert_hi_staged_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !sel_lo) |=> (hi_work == $past(hi_work)));

  assert_commit_pair_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel_lo) |=> (div == {$past(hi_pend), $past(wr_data)}));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    (ovs_tick && div > DIV_W'(1) && !commit) |=> !ovs_tick);

  assert_idle_clear_R7: assert property (@(posedge clk) disable iff (rst)
    !(rx_en || tx_en) |=> (ovs_cnt == '0 && bit_cnt == '0));

  assert_zero_silent_R6: assert property (@(posedge clk) disable iff (rst)
    (div == '0) |-> !ovs_tick && !bit_tick);
endmodule

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1, sel_lo = 0, wr_en = 0, rx_en = 0, tx_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic ovs_tick, bit_tick;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_tick_gen dut_i (
    .clk(clk), .rst(rst), .sel_lo(sel_lo), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .rx_en(rx_en), .tx_en(tx_en),
    .ovs_tick(ovs_tick), .bit_tick(bit_tick));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic lo, input logic [7:0] d);
    @(negedge clk); sel_lo = lo; wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0; #1;
  endtask

  task automatic rd(input logic lo, input int exp, input string req);
    sel_lo = lo; #1;
    check(req, rd_data, exp);
  endtask

  task automatic set_en(input logic r, input logic t);
    @(negedge clk); rx_en = r; tx_en = t; #1;
  endtask

  // Counter assumed freshly restarted at the current sample point (index 0).
  task automatic check_ticks(input int br, input int ncyc, input string req);
    int bad = 0, first_bad = -1;
    for (int i = 0; i < ncyc; i++) begin
      logic eo, eb;
      if (i > 0) begin @(negedge clk); #1; end
      eo = (br != 0) && (i % br == br - 1);
      eb = (br != 0) && (i % (16*br) == 16*br - 1);
      if (ovs_tick !== eo || bit_tick !== eb) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
    end
    if (bad != 0) $display("  tick mismatch for BR=%0d first at cycle %0d", br, first_bad);
    check(req, bad, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 0; #1;
    rd(0, 8'h00, "R1 upper reset");
    rd(1, 8'h04, "R1 lower reset");
    check_ticks(0, 20, "R1 R7 idle after reset");
  endtask

  task automatic t_default_rate;
    set_en(0, 1);
    check_ticks(4, 128, "R4 R5 R8 reset divisor via tx_en");
    set_en(0, 0);
    set_en(1, 0);
    check_ticks(4, 40, "R7 rx_en alone starts");
  endtask

  task automatic t_staging;
    wr(0, 8'h01);
    rd(0, 8'h00, "R2 upper staged only");
    rd(1, 8'h04, "R2 lower untouched");
    wr(1, 8'h02);
    check_ticks(258, 16*258, "R3 R5 R8 commit restarts with 258");
    rd(0, 8'h01, "R3 upper committed");
    rd(1, 8'h02, "R3 lower committed");
  endtask

  task automatic t_upper_bits;
    wr(0, 8'hFF);
    rd(0, 8'h01, "R2 upper unchanged before commit");
    wr(1, 8'hFF);
    check_ticks(8191, 2*8191, "R4 R8 maximum divisor");
    rd(0, 8'h1F, "R9 upper bits 7:5 read zero");
  endtask

  task automatic t_br1;
    wr(0, 8'h00);
    wr(1, 8'h01);
    check_ticks(1, 48, "R4 R5 divisor 1");
  endtask

  task automatic t_restart;
    wr(1, 8'h05);
    check_ticks(5, 3, "R8 first period");
    set_en(0, 0);
    set_en(1, 0);
    check_ticks(5, 90, "R8 R7 restart on enable");
    wr(1, 8'h05);
    check_ticks(5, 90, "R8 restart on commit mid-count");
  endtask

  task automatic t_zero;
    wr(0, 8'h00);
    wr(1, 8'h00);
    check_ticks(0, 100, "R6 zero divisor silent");
    rd(1, 8'h00, "R6 zero divisor readback");
    set_en(1, 1);
    check_ticks(0, 20, "R6 zero divisor both enables");
  endtask

  initial begin
    t_reset();
    t_default_rate();
    t_staging();
    t_upper_bits();
    t_br1();
    t_restart();
    t_zero();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule